// File: doc/BRIEF.md
# Shared-Memory Bus-Master DMA Engine

This block copies blocks of 32-bit words between an on-chip shared memory and a 32-bit external memory space, acting as the master on a simple valid/ready port. Two register ports exist, one for the host side and one for the local side. Each port can load a shared-memory word offset, an external byte address and a length, and then launch the copy in either direction with a single write to the low byte of the control register. Every beat moves a whole word with all byte lanes active, so lengths are always multiples of four bytes. The largest transfer fills the whole shared memory (16 KB at the default depth).

Software clears the completion flag, programs the three address/length registers, and writes the control low byte. That write selects the direction and starts the engine in the same access. It then polls the completion flag, or enables it onto the interrupt output. Either side can claim exclusive access through its own ownership bit, so the other side cannot corrupt a setup that is in progress. The local side also reaches the shared memory through a word port while the engine is idle.

Top module: `smdma_engine`

## Requirements
- R1: After reset, all four registers read 0, `irq` is low and `mst_valid` is low.
- R2: Register 0 (shared-memory base), register 1 (external base) and register 2 (size) take byte values with bits 1:0 forced to 0 on read. Register 0 and register 2 keep only the bits that index the shared memory (bits 7:2 for a 64-word memory).
- R3: A write with byte enable 0 set to register 3 while idle starts a transfer, and bit 0 of that byte sets the direction (1: shared memory to external, 0: external to shared memory). Register 3 bit 1 reads 1 from that point until the transfer ends.
- R4: A size value S moves S/4+1 words. The external addresses are the external base, base+4, base+8 and so on, one per accepted beat.
- R5: With direction 1, beat i carries shared-memory word base+i on `mst_wdata` with `mst_write` high.
- R6: With direction 0, `mst_write` is low, and the `mst_rdata` accepted on beat i is stored into shared-memory word base+i. Shared-memory words outside the range are unchanged.
- R7: While `mst_ready` stays high, `mst_valid` stays high and one word moves per clock. While `mst_ready` is low, address, direction and write data hold steady.
- R8: Register 3 bit 21 is set when the last beat is accepted, and writing 1 to it through byte enable 2 clears it. Register 3 bit 22 is a read/write enable, and `irq` is high exactly when bits 21 and 22 are both set.
- R9: A start write issued while a transfer runs is ignored: the transfer is neither restarted nor re-directed.
- R10: Register 3 bit 8 (host) and bit 9 (local) are ownership bits, and each side writes only its own bit through byte enable 1. A register write from one side is dropped while the other side's bit is set, so a claim succeeds only when the opposite bit is clear. When both sides write in the same cycle and neither side owns, the host write takes effect and the local write is dropped.
- R11: A local shared-memory write is dropped while a transfer runs. When the engine is idle, a local read returns the addressed word one clock later.
- R12: The shared-memory word index wraps modulo the memory depth when base+length passes its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | 2 | Host register select (0 local base, 1 external base, 2 size, 3 control/status) |
| hst_be | input | 4 | Host byte enables, used by register 3 |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` |
| loc_wr | input | 1 | Local register write strobe |
| loc_addr | input | 2 | Local register select |
| loc_be | input | 4 | Local byte enables |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data for `loc_addr` |
| loc_mem_we | input | 1 | Local shared-memory write enable |
| loc_mem_addr | input | log2(SM_WORDS) | Local shared-memory word address |
| loc_mem_wdata | input | 32 | Local shared-memory write data |
| loc_mem_rdata | output | 32 | Shared-memory read data, one clock after the address |
| mst_valid | output | 1 | Master beat request |
| mst_write | output | 1 | 1: beat writes external memory; 0: beat reads it |
| mst_addr | output | 32 | External byte address of the beat |
| mst_wdata | output | 32 | Write data of the beat |
| mst_ready | input | 1 | Far side accepts the beat this cycle |
| mst_rdata | input | 32 | Read data, valid in the accepting cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take for granted that the far side returns `mst_rdata` in the same cycle it raises `mst_ready`. They also assume that nothing but the engine writes the shared memory while a transfer runs, which the block enforces by dropping local writes. `mst_ready` may otherwise change freely. The stimulus changes `mst_ready` and every register or memory input only between clock edges. Its ready patterns are either constantly high or low one cycle in three. It keeps every external address inside the bench's 256-word model, and it clears the completion flag before each start as software would.

// File: rtl/smdma_engine.sv
`timescale 1ns/1ps
module smdma_engine #(
  parameter int SM_WORDS = 4096,
  localparam int PW = $clog2(SM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic [1:0]    hst_addr,
  input  logic [3:0]    hst_be,
  input  logic [31:0]   hst_wdata,
  output logic [31:0]   hst_rdata,
  input  logic          loc_wr,
  input  logic [1:0]    loc_addr,
  input  logic [3:0]    loc_be,
  input  logic [31:0]   loc_wdata,
  output logic [31:0]   loc_rdata,
  input  logic          loc_mem_we,
  input  logic [PW-1:0] loc_mem_addr,
  input  logic [31:0]   loc_mem_wdata,
  output logic [31:0]   loc_mem_rdata,
  output logic          mst_valid,
  output logic          mst_write,
  output logic [31:0]   mst_addr,
  output logic [31:0]   mst_wdata,
  input  logic          mst_ready,
  input  logic [31:0]   mst_rdata,
  output logic          irq
);
  localparam logic [PW-1:0] PONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_PRIME, S_RUN} st_t;

  st_t            st_q;
  logic [PW-1:0]  lbase_q, size_q, sm_ptr, cnt_q;
  logic [29:0]    hbase_q, ha_q;
  logic           dir_q, own_h, own_l, done_q, ien_q;
  logic           busy, fire, last, start;

  logic           h_ok, l_ok, w_en, w_host;
  logic [1:0]     w_addr;
  logic [3:0]     w_be;
  logic [31:0]    w_data;

  logic [31:0]    mem [SM_WORDS];
  logic [31:0]    mem_q;
  logic [PW-1:0]  raddr, waddr;
  logic           mwe;
  logic [31:0]    mwd;
  logic [31:0]    regv [4];
  logic           unused_bits;

  assign busy  = (st_q != S_IDLE);
  assign fire  = (st_q == S_RUN) && mst_ready;
  assign last  = fire && (cnt_q == '0);

  always_comb begin
    h_ok   = hst_wr && !own_l;
    l_ok   = loc_wr && !own_h && !h_ok;
    w_en   = h_ok || l_ok;
    w_host = h_ok;
    w_addr = h_ok ? hst_addr  : loc_addr;
    w_be   = h_ok ? hst_be    : loc_be;
    w_data = h_ok ? hst_wdata : loc_wdata;
  end

  assign start       = w_en && (w_addr == 2'd3) && w_be[0] && !busy;
  assign unused_bits = w_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lbase_q <= '0;
      hbase_q <= '0;
      size_q  <= '0;
      dir_q   <= 1'b0;
      own_h   <= 1'b0;
      own_l   <= 1'b0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (w_en) begin
        case (w_addr)
          2'd0: lbase_q <= w_data[PW+1:2];
          2'd1: hbase_q <= w_data[31:2];
          2'd2: size_q  <= w_data[PW+1:2];
          default: begin
            if (w_be[1]) begin
              if (w_host) own_h <= w_data[8];
              else        own_l <= w_data[9];
            end
            if (w_be[2]) begin
              ien_q <= w_data[22];
              if (w_data[21]) done_q <= 1'b0;
            end
            if (w_be[0] && !busy) dir_q <= w_data[0];
          end
        endcase
      end
      if (last) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sm_ptr <= '0;
      cnt_q  <= '0;
      ha_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_PRIME;
          sm_ptr <= lbase_q;
          cnt_q  <= size_q;
          ha_q   <= hbase_q;
        end
        S_PRIME: st_q <= S_RUN;
        default: if (fire) begin
          sm_ptr <= sm_ptr + PONE;
          ha_q   <= ha_q + 30'd1;
          cnt_q  <= cnt_q - PONE;
          if (cnt_q == '0) st_q <= S_IDLE;
        end
      endcase
    end
  end

  assign raddr = busy ? (fire ? sm_ptr + PONE : sm_ptr) : loc_mem_addr;
  assign waddr = busy ? sm_ptr : loc_mem_addr;
  assign mwe   = busy ? (fire && !dir_q) : loc_mem_we;
  assign mwd   = busy ? mst_rdata : loc_mem_wdata;

  always_ff @(posedge clk) begin
    if (mwe) mem[waddr] <= mwd;
    mem_q <= mem[raddr];
  end

  always_comb begin
    regv[0] = {{(30-PW){1'b0}}, lbase_q, 2'b00};
    regv[1] = {hbase_q, 2'b00};
    regv[2] = {{(30-PW){1'b0}}, size_q, 2'b00};
    regv[3] = '0;
    regv[3][0]  = dir_q;
    regv[3][1]  = busy;
    regv[3][8]  = own_h;
    regv[3][9]  = own_l;
    regv[3][21] = done_q;
    regv[3][22] = ien_q;
  end

  assign hst_rdata     = regv[hst_addr];
  assign loc_rdata     = regv[loc_addr];
  assign loc_mem_rdata = mem_q;
  assign mst_valid     = (st_q == S_RUN);
  assign mst_write     = dir_q;
  assign mst_addr      = {ha_q, 2'b00};
  assign mst_wdata     = mem_q;
  assign irq           = done_q && ien_q;
endmodule

// File: rtl/smdma_engine_sva.sv
`timescale 1ns/1ps
module smdma_engine_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        mst_valid,
  input logic        mst_ready,
  input logic        mst_write,
  input logic [31:0] mst_addr,
  input logic [31:0] mst_wdata,
  input logic        busy,
  input logic        done,
  input logic        own_h,
  input logic        own_l
);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && mst_ready |=> !mst_valid || (mst_addr == $past(mst_addr) + 32'd4));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && !mst_ready |=> mst_valid && $stable(mst_addr) && $stable(mst_write)
                                && (!mst_write || $stable(mst_wdata)));

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_dir_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(mst_write));

  assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_h && own_l));
endmodule

bind smdma_engine smdma_engine_sva u_sva (
  .clk(clk), .rst_n(rst_n), .mst_valid(mst_valid), .mst_ready(mst_ready),
  .mst_write(mst_write), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
  .busy(busy), .done(done_q), .own_h(own_h), .own_l(own_l)
);

// File: tb/smdma_engine_test.sv
`timescale 1ns/1ps
module smdma_engine_test;
  localparam int W  = 64;
  localparam int PW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic hst_wr = 0, loc_wr = 0, loc_mem_we = 0, mst_ready = 0;
  logic [1:0] hst_addr = 0, loc_addr = 0;
  logic [3:0] hst_be = 0, loc_be = 0;
  logic [31:0] hst_wdata = 0, loc_wdata = 0, loc_mem_wdata = 0;
  logic [PW-1:0] loc_mem_addr = 0;
  logic [31:0] hst_rdata, loc_rdata, loc_mem_rdata, mst_addr, mst_wdata, mst_rdata;
  logic mst_valid, mst_write, irq;

  logic [31:0] ext [256];
  logic [31:0] sm_model [W];
  logic [31:0] log_addr [W];
  int beats, vcyc, stall_err, cyc, rmode;
  bit prev_stall;
  logic [31:0] prev_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  smdma_engine #(.SM_WORDS(W)) uut (
    .clk, .rst_n, .hst_wr, .hst_addr, .hst_be, .hst_wdata, .hst_rdata,
    .loc_wr, .loc_addr, .loc_be, .loc_wdata, .loc_rdata,
    .loc_mem_we, .loc_mem_addr, .loc_mem_wdata, .loc_mem_rdata,
    .mst_valid, .mst_write, .mst_addr, .mst_wdata, .mst_ready, .mst_rdata, .irq
  );

  assign mst_rdata = ext[mst_addr[9:2]];

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    mst_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (mst_valid) vcyc = vcyc + 1;
    if (prev_stall && mst_valid && mst_addr != prev_addr) stall_err = stall_err + 1;
    prev_stall = mst_valid && !mst_ready;
    prev_addr  = mst_addr;
    if (mst_valid && mst_ready) begin
      if (beats < W) log_addr[beats] = mst_addr;
      beats = beats + 1;
      if (mst_write) ext[mst_addr[9:2]] = mst_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_be = be; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic lwr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); loc_wr = 1; loc_addr = a; loc_be = be; loc_wdata = d;
    @(negedge clk); loc_wr = 0;
  endtask

  task automatic bothwr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] hd, input logic [31:0] ld);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_be = be; hst_wdata = hd;
    loc_wr = 1; loc_addr = a; loc_be = be; loc_wdata = ld;
    @(negedge clk); hst_wr = 0; loc_wr = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); hst_addr = a; #1 d = hst_rdata;
  endtask

  task automatic mwr(input int a, input logic [31:0] d);
    @(negedge clk); loc_mem_we = 1; loc_mem_addr = PW'(a); loc_mem_wdata = d;
    @(negedge clk); loc_mem_we = 0;
  endtask

  task automatic mrd(input int a, output logic [31:0] d);
    @(negedge clk); loc_mem_addr = PW'(a);
    @(negedge clk); d = loc_mem_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      hrd(2'd3, d);
      if (!d[1]) return;
    end
    chk("R3", "busy never cleared", 1, 0);
  endtask

  task automatic run_xfer(input bit dir, input int lb, input int n, input int rm, input bit poke);
    int hb, bad;
    logic [31:0] d;
    string wreq;
    hb = 40 + lb;
    wreq = (lb + n > W) ? "R12" : (dir ? "R5" : "R6");
    for (int i = 0; i < W; i++) begin
      sm_model[i] = 32'h5A00_0000 + (32'(dir) << 20) + (32'(lb) << 12) + 32'(i);
      mwr(i, sm_model[i]);
    end
    for (int i = 0; i < n; i++)
      ext[hb+i] = dir ? 32'hDEAD_BEEF : (32'hC300_0000 ^ (32'(hb + i) << 4) ^ 32'(lb));
    hwr(2'd3, 4'b0100, (32'(rm) << 22) | (32'd1 << 21));
    hwr(2'd0, 4'hF, 32'(lb * 4) | 32'd3);
    hwr(2'd1, 4'hF, 32'(hb * 4) | 32'd1);
    hwr(2'd2, 4'hF, 32'((n - 1) * 4) | 32'd2);
    @(negedge clk);
    rmode = rm; beats = 0; vcyc = 0; stall_err = 0; prev_stall = 0;
    hwr(2'd3, 4'b0001, 32'(dir));
    hrd(2'd3, d);
    chk("R3", "busy after start", 32'(d[1]), 1);
    if (poke) begin
      hwr(2'd3, 4'b0001, 32'(!dir));
      mwr(lb, 32'hBAD0_0BAD);
    end
    wait_idle();
    chk("R4", "beat count", 32'(beats), 32'(n));
    bad = 0;
    for (int i = 0; i < n && i < W; i++)
      if (log_addr[i] != 32'((hb + i) * 4)) bad++;
    chk("R4", "address sequence mismatches", 32'(bad), 0);
    chk("R7", "address moved during stall", 32'(stall_err), 0);
    if (rm == 0) chk("R7", "valid cycles with ready high", 32'(vcyc), 32'(n));
    hrd(2'd3, d);
    chk("R8", "completion bit", 32'(d[21]), 1);
    chk("R8", "irq equals done and enable", 32'(irq), 32'(rm));
    if (poke) begin
      chk("R9", "direction after ignored start", 32'(d[0]), 32'(dir));
      mrd(lb, d);
      chk("R11", "local write during transfer", d, sm_model[lb]);
    end
    bad = 0;
    if (dir) begin
      for (int i = 0; i < n; i++)
        if (ext[hb+i] != sm_model[(lb + i) % W]) bad++;
    end else begin
      for (int i = 0; i < W; i++) begin
        int off;
        logic [31:0] e;
        off = (i - lb + W) % W;
        e = (off < n) ? ext[hb+off] : sm_model[i];
        mrd(i, d);
        if (d != e) bad++;
      end
    end
    chk(wreq, "data word mismatches", 32'(bad), 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lbs[6];
    int ns[6];
    lbs = '{0, 5, 10, 0, 60, 17};
    ns  = '{1, 2, 3, 64, 8, 20};
    rmode = 0; cyc = 0; beats = 0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      hrd(2'(a), d);
      chk("R1", "register reset value", d, 0);
    end
    chk("R1", "irq in reset", 32'(irq), 0);
    chk("R1", "mst_valid in reset", 32'(mst_valid), 0);
    @(negedge clk); rst_n = 1;

    hwr(2'd0, 4'hF, 32'hFFFF_FFFF); hrd(2'd0, d); chk("R2", "local base readback", d, 32'h0000_00FC);
    hwr(2'd1, 4'hF, 32'h1234_5677); hrd(2'd1, d); chk("R2", "external base readback", d, 32'h1234_5674);
    hwr(2'd2, 4'hF, 32'hFFFF_FFFF); hrd(2'd2, d); chk("R2", "size readback", d, 32'h0000_00FC);

    mwr(7, 32'h0BAD_CAFE); mrd(7, d); chk("R11", "idle local read", d, 32'h0BAD_CAFE);

    for (int dir = 0; dir < 2; dir++)
      for (int k = 0; k < 6; k++)
        for (int rm = 0; rm < 2; rm++)
          run_xfer(dir[0], lbs[k], ns[k], rm, 1'b0);

    hwr(2'd3, 4'b0100, (32'd1 << 22) | (32'd1 << 21));
    hrd(2'd3, d);
    chk("R8", "done cleared by write one", 32'(d[21]), 0);
    chk("R8", "irq low after clear", 32'(irq), 0);

    run_xfer(1'b1, 3, 64, 0, 1'b1);

    lwr(2'd3, 4'b0010, 32'd1 << 9);
    hrd(2'd3, d); chk("R10", "local claim", 32'(d[9]), 1);
    hrd(2'd0, d);
    hwr(2'd0, 4'hF, 32'd8 << 2);
    begin
      logic [31:0] d2;
      hrd(2'd0, d2); chk("R10", "host write dropped while local owns", d2, d);
    end
    hwr(2'd3, 4'b0010, 32'd1 << 8);
    hrd(2'd3, d); chk("R10", "host claim refused", 32'(d[8]), 0);
    lwr(2'd0, 4'hF, 32'd12 << 2);
    hrd(2'd0, d); chk("R10", "owner write accepted", d, 32'd48);
    lwr(2'd3, 4'b0010, 0);
    hwr(2'd3, 4'b0010, 32'd1 << 8);
    hrd(2'd3, d); chk("R10", "host claim", 32'(d[8]), 1);
    lwr(2'd0, 4'hF, 32'd2 << 2);
    hrd(2'd0, d); chk("R10", "local write dropped while host owns", d, 32'd48);
    hwr(2'd3, 4'b0010, 0);
    bothwr(2'd0, 4'hF, 32'd4 << 2, 32'd9 << 2);
    hrd(2'd0, d); chk("R10", "simultaneous write host wins", d, 32'd16);
    bothwr(2'd3, 4'b0010, 32'd1 << 8, 32'd1 << 9);
    hrd(2'd3, d); chk("R10", "simultaneous claim bits", {30'd0, d[9:8]}, 32'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule